// File: doc/BRIEF.md
# Interrupt Cause Register Aggregator

This block collects hardware event pulses from three sources (receive, transmit and miscellaneous) into three 32-bit cause registers. Each cause bit can be masked and can be configured to clear either when the cause register is read or when software writes a 1 to it. Software can also raise any cause bit by writing to a set register, which makes software-triggered interrupts possible.

A summary register keeps one bit per unit. Each bit is set whenever that unit has at least one unmasked cause bit pending, and the whole register clears when it is read. A separate summary mask sits between the summary register and the single level-sensitive interrupt output. Software normally reads the summary first, then services the units it flags.

Registers are reached through a word-addressed port. A read returns data in the same cycle. Any clearing that the read causes takes effect at the clock edge that ends the read cycle.

Top module: `irq_cause_aggregator`

## Requirements
- R1: After synchronous reset every unit mask reads 0xFFFFFFFF, every cause, clear-mode and masked-cause register reads 0, the summary mask reads 0x7, the summary reads 0 and irq_out is low.
- R2: A write to a unit's mask-set register (unit offset 2) sets each mask bit whose data bit is 1 and leaves the other mask bits unchanged.
- R3: A write to a unit's mask-clear register (unit offset 3) clears each mask bit whose data bit is 1 and leaves the other mask bits unchanged.
- R4: A cause bit whose clear-mode bit (unit offset 4) is 1 clears at the edge that ends a read of the cause register (unit offset 0). The read returns the value held before the clear.
- R5: A write of 1 to a cause bit whose clear-mode bit is 0 clears that bit. Writing 1 to a cause bit whose clear-mode bit is 1 leaves it set, and writing 0 never clears.
- R6: A write to a unit's cause-set register (unit offset 1) sets every cause bit whose data bit is 1.
- R7: A one-cycle pulse on hw_evt bit u*32+i sets cause bit i of unit u (unit 0 receive, 1 transmit, 2 misc), and the bit stays set until it is cleared.
- R8: When an event pulse arrives in the same cycle as a clear of the same bit, whether by write-1 or by read, the cause bit is set after that edge.
- R9: Summary bit u (summary register at address 24) is set one edge after unit u has any cause bit with a clear mask bit. It stays set until the summary is read, even if the cause is cleared in the meantime.
- R10: Reading the summary returns its current value and clears it at the end of the read. A bit whose unit still has an unmasked pending cause sets again on the following edge.
- R11: irq_out is high exactly when some summary bit is set while its summary-mask bit (address 25, bits 2:0) is 0. A summary mask of all ones holds irq_out low.
- R12: A unit's mask readback (offset 5) returns its mask. Its masked-cause readback (offset 6) returns the cause ANDed with the inverted mask. Offsets 1, 2, 3 and 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_evt | input | NUM_UNITS*CAUSE_W | Event pulses, unit u occupies bits u*CAUSE_W upward |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives read side effects) |
| reg_addr | input | ADDR_W | Word address: unit u at u*8+offset, summary block at NUM_UNITS*8 |
| reg_wdata | input | CAUSE_W | Write data |
| reg_rdata | output | CAUSE_W | Read data, valid in the cycle of the read |
| irq_out | output | 1 | Level interrupt output |

## Verification
The assertions assume that reg_wr and reg_rd are never high together on the same address, and that hw_evt bits are single-cycle pulses sampled at the clock edge. The assertions also rely on mask writes reaching only offsets 2 and 3, so that no other write can change a mask in the same cycle. The bench drives at most one access per cycle. It pulses events for exactly one cycle, and its only overlapping stimulus is the deliberate event-versus-clear case. Between accesses it inserts a settle cycle, so every summary update has landed before the next sample.

// File: rtl/irq_agg_pkg.sv
// Package: irq_agg_pkg
// Shared register offsets and address layout for the interrupt cause
// aggregator. Each unit owns an 8-word window; the summary block follows
// the last unit.
package irq_agg_pkg;

    localparam int STRIDE_LG = 3;

    typedef enum logic [STRIDE_LG-1:0] {
        OFF_CAUSE = 3'd0,
        OFF_SET   = 3'd1,
        OFF_MSET  = 3'd2,
        OFF_MCLR  = 3'd3,
        OFF_MODE  = 3'd4,
        OFF_MASK  = 3'd5,
        OFF_PEND  = 3'd6
    } unit_off_e;

    localparam logic [STRIDE_LG-1:0] OFF_SUMMARY = 3'd0;
    localparam logic [STRIDE_LG-1:0] OFF_SUMMASK = 3'd1;

endpackage

// File: rtl/irq_cause_unit.sv
// Module: irq_cause_unit
// One cause register with its mask and per-bit clear mode.
// Assumes: at most one write strobe is active per cycle, and evt_i bits
// are pulses sampled on the rising edge. Event and software set always
// win over a clear of the same bit in the same cycle.
module irq_cause_unit #(
    parameter int CAUSE_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CAUSE_W-1:0] evt_i,
    input  logic [CAUSE_W-1:0] wdata_i,
    input  logic               wr_cause_i,
    input  logic               wr_set_i,
    input  logic               wr_mset_i,
    input  logic               wr_mclr_i,
    input  logic               wr_mode_i,
    input  logic               rd_cause_i,
    output logic [CAUSE_W-1:0] cause_o,
    output logic [CAUSE_W-1:0] mask_o,
    output logic [CAUSE_W-1:0] mode_o,
    output logic [CAUSE_W-1:0] pend_o,
    output logic               any_o
);

    logic [CAUSE_W-1:0] cause_q;
    logic [CAUSE_W-1:0] mask_q;
    logic [CAUSE_W-1:0] mode_q;
    logic [CAUSE_W-1:0] clr_w1c;
    logic [CAUSE_W-1:0] clr_rd;
    logic [CAUSE_W-1:0] sw_set;
    logic [CAUSE_W-1:0] cause_d;
    logic [CAUSE_W-1:0] mask_d;

    // Purpose: form the clear and set vectors for this cycle.
    always_comb begin
        clr_w1c = wr_cause_i ? (wdata_i & ~mode_q) : '0;
        clr_rd  = rd_cause_i ? mode_q : '0;
        sw_set  = wr_set_i ? wdata_i : '0;
        cause_d = (cause_q & ~(clr_w1c | clr_rd)) | evt_i | sw_set;
    end

    // Purpose: apply mask set or mask clear writes.
    always_comb begin
        mask_d = mask_q;
        if (wr_mset_i) begin
            mask_d = mask_q | wdata_i;
        end else if (wr_mclr_i) begin
            mask_d = mask_q & ~wdata_i;
        end
    end

    // Purpose: hold cause, mask and clear-mode state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= '0;
            mask_q  <= '1;
            mode_q  <= '0;
        end else begin
            cause_q <= cause_d;
            mask_q  <= mask_d;
            if (wr_mode_i) begin
                mode_q <= wdata_i;
            end
        end
    end

    // Purpose: present state and the masked pending view.
    always_comb begin
        cause_o = cause_q;
        mask_o  = mask_q;
        mode_o  = mode_q;
        pend_o  = cause_q & ~mask_q;
        any_o   = |pend_o;
    end

endmodule

// File: rtl/irq_pseudo_summary.sv
// Module: irq_pseudo_summary
// Summary register with one bit per unit, cleared on read, and the
// summary mask that gates the level interrupt output.
// Assumes: any_i is the per-unit "unmasked cause pending" flag; a pending
// unit sets its bit again on the edge after a clearing read.
module irq_pseudo_summary #(
    parameter int NUM_UNITS = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_UNITS-1:0] any_i,
    input  logic                 rd_clr_i,
    input  logic                 wr_mask_i,
    input  logic [NUM_UNITS-1:0] wdata_i,
    output logic [NUM_UNITS-1:0] summary_o,
    output logic [NUM_UNITS-1:0] smask_o,
    output logic                 irq_o
);

    logic [NUM_UNITS-1:0] summary_q;
    logic [NUM_UNITS-1:0] smask_q;

    // Purpose: accumulate unit flags, clear on read, hold the summary mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            summary_q <= '0;
            smask_q   <= '1;
        end else begin
            summary_q <= (rd_clr_i ? '0 : summary_q) | any_i;
            if (wr_mask_i) begin
                smask_q <= wdata_i;
            end
        end
    end

    // Purpose: drive outputs and the gated interrupt level.
    always_comb begin
        summary_o = summary_q;
        smask_o   = smask_q;
        irq_o     = |(summary_q & ~smask_q);
    end

endmodule

// File: rtl/irq_reg_decode.sv
// Module: irq_reg_decode
// Address decode into per-unit strobes and the read data multiplexer.
// Assumes: word addresses; unit u at u*8+offset, summary block at
// NUM_UNITS*8. Unmapped or write-only offsets read as zero.
module irq_reg_decode
    import irq_agg_pkg::*;
#(
    parameter int NUM_UNITS = 3,
    parameter int CAUSE_W   = 32,
    parameter int ADDR_W    = 5
) (
    input  logic                           reg_wr,
    input  logic                           reg_rd,
    input  logic [ADDR_W-1:0]              reg_addr,
    input  logic [NUM_UNITS*CAUSE_W-1:0]   cause_flat,
    input  logic [NUM_UNITS*CAUSE_W-1:0]   mask_flat,
    input  logic [NUM_UNITS*CAUSE_W-1:0]   mode_flat,
    input  logic [NUM_UNITS*CAUSE_W-1:0]   pend_flat,
    input  logic [NUM_UNITS-1:0]           summary,
    input  logic [NUM_UNITS-1:0]           smask,
    output logic [NUM_UNITS-1:0]           wr_cause,
    output logic [NUM_UNITS-1:0]           wr_set,
    output logic [NUM_UNITS-1:0]           wr_mset,
    output logic [NUM_UNITS-1:0]           wr_mclr,
    output logic [NUM_UNITS-1:0]           wr_mode,
    output logic [NUM_UNITS-1:0]           rd_cause,
    output logic                           wr_smask,
    output logic                           rd_summary,
    output logic [CAUSE_W-1:0]             reg_rdata
);

    localparam int BLK_W = ADDR_W - STRIDE_LG;
    localparam logic [BLK_W-1:0] SUM_BLK = BLK_W'(NUM_UNITS);

    logic [BLK_W-1:0]     blk;
    logic [STRIDE_LG-1:0] off;

    assign blk = reg_addr[ADDR_W-1:STRIDE_LG];
    assign off = reg_addr[STRIDE_LG-1:0];

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_strobe
        localparam logic [BLK_W-1:0] U_BLK = BLK_W'(u);
        logic hit;
        assign hit         = (blk == U_BLK);
        assign wr_cause[u] = reg_wr & hit & (off == OFF_CAUSE);
        assign wr_set[u]   = reg_wr & hit & (off == OFF_SET);
        assign wr_mset[u]  = reg_wr & hit & (off == OFF_MSET);
        assign wr_mclr[u]  = reg_wr & hit & (off == OFF_MCLR);
        assign wr_mode[u]  = reg_wr & hit & (off == OFF_MODE);
        assign rd_cause[u] = reg_rd & hit & (off == OFF_CAUSE);
    end

    assign wr_smask   = reg_wr & (blk == SUM_BLK) & (off == OFF_SUMMASK);
    assign rd_summary = reg_rd & (blk == SUM_BLK) & (off == OFF_SUMMARY);

    // Purpose: select read data from the addressed unit or summary block.
    always_comb begin
        reg_rdata = '0;
        for (int u = 0; u < NUM_UNITS; u++) begin
            if (blk == BLK_W'(u)) begin
                case (off)
                    OFF_CAUSE: reg_rdata = cause_flat[u*CAUSE_W +: CAUSE_W];
                    OFF_MODE:  reg_rdata = mode_flat[u*CAUSE_W +: CAUSE_W];
                    OFF_MASK:  reg_rdata = mask_flat[u*CAUSE_W +: CAUSE_W];
                    OFF_PEND:  reg_rdata = pend_flat[u*CAUSE_W +: CAUSE_W];
                    default:   reg_rdata = '0;
                endcase
            end
        end
        if (blk == SUM_BLK) begin
            if (off == OFF_SUMMARY) begin
                reg_rdata[NUM_UNITS-1:0] = summary;
            end else if (off == OFF_SUMMASK) begin
                reg_rdata[NUM_UNITS-1:0] = smask;
            end
        end
    end

endmodule

// File: rtl/irq_cause_aggregator.sv
// Module: irq_cause_aggregator (top)
// Several interrupt cause units feeding a clear-on-read summary register
// and one masked level interrupt line.
// Assumes: CAUSE_W >= NUM_UNITS; one register access per cycle.
module irq_cause_aggregator #(
    parameter int NUM_UNITS = 3,
    parameter int CAUSE_W   = 32,
    localparam int ADDR_W   = $clog2((NUM_UNITS + 1) * 8)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_UNITS*CAUSE_W-1:0] hw_evt,
    input  logic                         reg_wr,
    input  logic                         reg_rd,
    input  logic [ADDR_W-1:0]            reg_addr,
    input  logic [CAUSE_W-1:0]           reg_wdata,
    output logic [CAUSE_W-1:0]           reg_rdata,
    output logic                         irq_out
);

    logic [NUM_UNITS*CAUSE_W-1:0] cause_flat;
    logic [NUM_UNITS*CAUSE_W-1:0] mask_flat;
    logic [NUM_UNITS*CAUSE_W-1:0] mode_flat;
    logic [NUM_UNITS*CAUSE_W-1:0] pend_flat;
    logic [NUM_UNITS-1:0]         unit_any;
    logic [NUM_UNITS-1:0]         wr_cause;
    logic [NUM_UNITS-1:0]         wr_set;
    logic [NUM_UNITS-1:0]         wr_mset;
    logic [NUM_UNITS-1:0]         wr_mclr;
    logic [NUM_UNITS-1:0]         wr_mode;
    logic [NUM_UNITS-1:0]         rd_cause;
    logic                         wr_smask;
    logic                         rd_summary;
    logic [NUM_UNITS-1:0]         summary_val;
    logic [NUM_UNITS-1:0]         smask_val;

    irq_reg_decode #(
        .NUM_UNITS(NUM_UNITS),
        .CAUSE_W  (CAUSE_W),
        .ADDR_W   (ADDR_W)
    ) i_decode (
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .cause_flat(cause_flat),
        .mask_flat (mask_flat),
        .mode_flat (mode_flat),
        .pend_flat (pend_flat),
        .summary   (summary_val),
        .smask     (smask_val),
        .wr_cause  (wr_cause),
        .wr_set    (wr_set),
        .wr_mset   (wr_mset),
        .wr_mclr   (wr_mclr),
        .wr_mode   (wr_mode),
        .rd_cause  (rd_cause),
        .wr_smask  (wr_smask),
        .rd_summary(rd_summary),
        .reg_rdata (reg_rdata)
    );

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        irq_cause_unit #(
            .CAUSE_W(CAUSE_W)
        ) i_unit (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt_i     (hw_evt[u*CAUSE_W +: CAUSE_W]),
            .wdata_i   (reg_wdata),
            .wr_cause_i(wr_cause[u]),
            .wr_set_i  (wr_set[u]),
            .wr_mset_i (wr_mset[u]),
            .wr_mclr_i (wr_mclr[u]),
            .wr_mode_i (wr_mode[u]),
            .rd_cause_i(rd_cause[u]),
            .cause_o   (cause_flat[u*CAUSE_W +: CAUSE_W]),
            .mask_o    (mask_flat[u*CAUSE_W +: CAUSE_W]),
            .mode_o    (mode_flat[u*CAUSE_W +: CAUSE_W]),
            .pend_o    (pend_flat[u*CAUSE_W +: CAUSE_W]),
            .any_o     (unit_any[u])
        );
    end

    irq_pseudo_summary #(
        .NUM_UNITS(NUM_UNITS)
    ) i_summary (
        .clk      (clk),
        .rst_n    (rst_n),
        .any_i    (unit_any),
        .rd_clr_i (rd_summary),
        .wr_mask_i(wr_smask),
        .wdata_i  (reg_wdata[NUM_UNITS-1:0]),
        .summary_o(summary_val),
        .smask_o  (smask_val),
        .irq_o    (irq_out)
    );

endmodule

// File: rtl/irq_agg_checker.sv
// Module: irq_agg_checker
// Concurrent checks on the aggregator, bound to the top module.
// Assumes: one register access per cycle, as stated in the brief.
module irq_agg_checker #(
    parameter int NUM_UNITS = 3,
    parameter int CAUSE_W   = 32,
    parameter int ADDR_W    = 5
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NUM_UNITS*CAUSE_W-1:0] hw_evt,
    input logic                         reg_wr,
    input logic                         reg_rd,
    input logic [ADDR_W-1:0]            reg_addr,
    input logic [CAUSE_W-1:0]           reg_wdata,
    input logic                         irq_out,
    input logic [NUM_UNITS*CAUSE_W-1:0] cause_flat,
    input logic [NUM_UNITS*CAUSE_W-1:0] mask_flat,
    input logic [NUM_UNITS*CAUSE_W-1:0] mode_flat,
    input logic [NUM_UNITS-1:0]         unit_any,
    input logic [NUM_UNITS-1:0]         summary_val,
    input logic [NUM_UNITS-1:0]         smask_val
);

    localparam logic [ADDR_W-1:0] SUM_ADDR = ADDR_W'(NUM_UNITS * 8);

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_chk
        localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(u * 8);
        localparam logic [ADDR_W-1:0] A_SET   = ADDR_W'(u * 8 + 1);
        localparam logic [ADDR_W-1:0] A_MSET  = ADDR_W'(u * 8 + 2);
        localparam logic [ADDR_W-1:0] A_MCLR  = ADDR_W'(u * 8 + 3);

        a_r2_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_addr == A_MSET)
            |=> ((mask_flat[u*CAUSE_W +: CAUSE_W] & $past(reg_wdata)) == $past(reg_wdata)));

        a_r3_mask_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_addr == A_MCLR)
            |=> ((mask_flat[u*CAUSE_W +: CAUSE_W] & $past(reg_wdata)) == '0));

        a_r5_cor_ignores_w1c: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_addr == A_CAUSE)
            |=> ((cause_flat[u*CAUSE_W +: CAUSE_W]
                  & $past(cause_flat[u*CAUSE_W +: CAUSE_W] & mode_flat[u*CAUSE_W +: CAUSE_W]))
                 == $past(cause_flat[u*CAUSE_W +: CAUSE_W] & mode_flat[u*CAUSE_W +: CAUSE_W])));

        a_r6_soft_set: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_addr == A_SET)
            |=> ((cause_flat[u*CAUSE_W +: CAUSE_W] & $past(reg_wdata)) == $past(reg_wdata)));
    end

    // R8: an event bit is always set after its edge, whatever clear ran.
    a_r8_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cause_flat & $past(hw_evt)) == $past(hw_evt)));

    // R9: a unit with an unmasked pending cause is flagged one edge later.
    a_r9_summary_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((summary_val & $past(unit_any)) == $past(unit_any)));

    a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == SUM_ADDR && unit_any == '0) |=> (summary_val == '0));

    a_r11_full_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (&smask_val) |-> !irq_out);

endmodule

bind irq_cause_aggregator irq_agg_checker #(
    .NUM_UNITS(NUM_UNITS),
    .CAUSE_W  (CAUSE_W),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hw_evt     (hw_evt),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .irq_out    (irq_out),
    .cause_flat (cause_flat),
    .mask_flat  (mask_flat),
    .mode_flat  (mode_flat),
    .unit_any   (unit_any),
    .summary_val(summary_val),
    .smask_val  (smask_val)
);

// File: tb/test_irq_cause_aggregator.sv
`timescale 1ns/1ps
// Bench for irq_cause_aggregator: a requirement-level model tracks the
// expected register state; sweeps cover every cause bit of every unit.
module test_irq_cause_aggregator;

    localparam int NU = 3;
    localparam int CW = 32;
    localparam logic [4:0] A_SUM  = 5'd24;
    localparam logic [4:0] A_SMSK = 5'd25;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NU*CW-1:0] hw_evt = '0;
    logic            reg_wr = 1'b0;
    logic            reg_rd = 1'b0;
    logic [4:0]      reg_addr = '0;
    logic [CW-1:0]   reg_wdata = '0;
    logic [CW-1:0]   reg_rdata;
    logic            irq_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [CW-1:0] m_cause [NU];
    logic [CW-1:0] m_mask  [NU];
    logic [CW-1:0] m_mode  [NU];
    logic [NU-1:0] m_sum;
    logic [NU-1:0] m_smask;

    irq_cause_aggregator i_irq_cause_aggregator (
        .clk      (clk),
        .rst_n    (rst_n),
        .hw_evt   (hw_evt),
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .irq_out  (irq_out)
    );

    always #2.5 clk = ~clk;

    function automatic logic [4:0] ua(input int u, input int off);
        return 5'(u * 8 + off);
    endfunction

    function automatic logic [NU-1:0] m_any();
        logic [NU-1:0] a;
        for (int u = 0; u < NU; u++) a[u] = |(m_cause[u] & ~m_mask[u]);
        return a;
    endfunction

    function automatic logic [CW-1:0] m_read(input logic [4:0] a);
        int blk = int'(a[4:3]);
        int off = int'(a[2:0]);
        if (blk < NU) begin
            case (off)
                0: return m_cause[blk];
                4: return m_mode[blk];
                5: return m_mask[blk];
                6: return m_cause[blk] & ~m_mask[blk];
                default: return '0;
            endcase
        end
        if (a == A_SUM)  return CW'(m_sum);
        if (a == A_SMSK) return CW'(m_smask);
        return '0;
    endfunction

    task automatic m_step(input logic wr, input logic rd, input logic [4:0] a,
                          input logic [CW-1:0] d, input logic [NU*CW-1:0] ev);
        logic [NU-1:0] any_old = m_any();
        int blk = int'(a[4:3]);
        int off = int'(a[2:0]);
        for (int u = 0; u < NU; u++) begin
            logic [CW-1:0] clr = '0;
            logic [CW-1:0] set = '0;
            if (blk == u) begin
                if (wr && off == 0) clr = d & ~m_mode[u];
                if (rd && off == 0) clr = clr | m_mode[u];
                if (wr && off == 1) set = d;
                if (wr && off == 2) m_mask[u] = m_mask[u] | d;
                if (wr && off == 3) m_mask[u] = m_mask[u] & ~d;
                if (wr && off == 4) m_mode[u] = d;
            end
            m_cause[u] = (m_cause[u] & ~clr) | ev[u*CW +: CW] | set;
        end
        m_sum = ((rd && a == A_SUM) ? '0 : m_sum) | any_old;
        if (wr && a == A_SMSK) m_smask = d[NU-1:0];
        m_sum = m_sum | m_any();
    endtask

    task automatic check(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // One access cycle plus one settle cycle; the model follows.
    task automatic op(input logic wr, input logic rd, input logic [4:0] a,
                      input logic [CW-1:0] d, input logic [NU*CW-1:0] ev,
                      input string tag, input bit do_chk);
        logic [CW-1:0] exp_rd = m_read(a);
        @(negedge clk);
        reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d; hw_evt = ev;
        #1;
        if (do_chk) check(tag, reg_rdata, exp_rd);
        @(negedge clk);
        reg_wr = 1'b0; reg_rd = 1'b0; hw_evt = '0;
        m_step(wr, rd, a, d, ev);
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [CW-1:0] d);
        op(1'b1, 1'b0, a, d, '0, "", 1'b0);
    endtask

    task automatic rd_reg(input logic [4:0] a, input string tag);
        op(1'b0, 1'b1, a, '0, '0, tag, 1'b1);
    endtask

    task automatic pulse(input logic [NU*CW-1:0] ev);
        op(1'b0, 1'b0, 5'd7, '0, ev, "", 1'b0);
    endtask

    task automatic chk_irq(input string tag);
        check(tag, CW'(irq_out), CW'(|(m_sum & ~m_smask)));
    endtask

    initial begin
        for (int u = 0; u < NU; u++) begin
            m_cause[u] = '0; m_mask[u] = '1; m_mode[u] = '0;
        end
        m_sum = '0; m_smask = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values
        for (int u = 0; u < NU; u++) begin
            rd_reg(ua(u, 5), "R1 mask reset");
            rd_reg(ua(u, 0), "R1 cause reset");
            rd_reg(ua(u, 4), "R1 mode reset");
            rd_reg(ua(u, 6), "R1 masked-cause reset");
        end
        rd_reg(A_SMSK, "R1 summary mask reset");
        rd_reg(A_SUM, "R1 summary reset");
        chk_irq("R1 irq reset");

        // R7/R12/R5: sweep every bit of every unit, masked
        for (int u = 0; u < NU; u++) begin
            for (int i = 0; i < CW; i++) begin
                pulse((NU*CW)'(1) << (u * CW + i));
                rd_reg(ua(u, 0), "R7 event latched");
                rd_reg(ua(u, 6), "R12 masked cause hidden");
                chk_irq("R9 masked cause no irq");
                wr_reg(ua(u, 0), CW'(1) << i);
                rd_reg(ua(u, 0), "R5 w1c clears");
            end
        end
        rd_reg(A_SUM, "R9 masked causes leave summary empty");

        // R2/R3: mask set and clear on every unit
        for (int u = 0; u < NU; u++) begin
            wr_reg(ua(u, 3), 32'h0000_FFFF);
            rd_reg(ua(u, 5), "R3 mask clear");
            wr_reg(ua(u, 2), 32'h0000_0F00);
            rd_reg(ua(u, 5), "R2 mask set");
            wr_reg(ua(u, 2), 32'h0);
            rd_reg(ua(u, 5), "R2 zero leaves mask");
            wr_reg(ua(u, 3), 32'h0);
            rd_reg(ua(u, 5), "R3 zero leaves mask");
            wr_reg(ua(u, 2), 32'hFFFF_FFFF);
            rd_reg(ua(u, 1), "R12 set offset reads zero");
            rd_reg(ua(u, 7), "R12 spare offset reads zero");
        end

        // R4/R5/R6: mixed clear modes on unit 1
        wr_reg(ua(1, 4), 32'hFF00_FF00);
        rd_reg(ua(1, 4), "R4 mode readback");
        wr_reg(ua(1, 1), 32'hFFFF_FFFF);
        rd_reg(ua(1, 0), "R6 soft set then R4 read");
        rd_reg(ua(1, 0), "R4 cor bits cleared");
        wr_reg(ua(1, 0), 32'hFFFF_FFFF);
        rd_reg(ua(1, 0), "R5 w1c bits cleared");
        wr_reg(ua(1, 1), 32'hFFFF_FFFF);
        wr_reg(ua(1, 0), 32'hFFFF_FFFF);
        rd_reg(ua(1, 0), "R5 w1c ignored on cor bits");
        rd_reg(ua(1, 0), "R4 cor read empties");
        wr_reg(ua(1, 1), 32'h0000_0003);
        wr_reg(ua(1, 0), 32'h0);
        rd_reg(ua(1, 0), "R5 write zero keeps");
        wr_reg(ua(1, 0), 32'h0000_0003);
        wr_reg(ua(1, 4), 32'h0);

        // R9/R10/R11: summary and interrupt line
        wr_reg(A_SMSK, 32'h0);
        wr_reg(ua(0, 3), 32'h0000_0008);
        pulse((NU*CW)'(1) << 3);
        chk_irq("R11 irq raised");
        rd_reg(A_SUM, "R9 summary bit0");
        rd_reg(A_SUM, "R10 pending sets again");
        rd_reg(ua(0, 6), "R12 masked cause visible");
        wr_reg(ua(0, 0), 32'h0000_0008);
        rd_reg(A_SUM, "R9 summary held after cause cleared");
        rd_reg(A_SUM, "R10 summary cleared by read");
        chk_irq("R11 irq drops");

        wr_reg(ua(1, 3), 32'hFFFF_FFFF);
        wr_reg(ua(2, 3), 32'h0000_0001);
        pulse(((NU*CW)'(1) << 3) | ((NU*CW)'(1) << (CW + 7)) | ((NU*CW)'(1) << (2*CW)));
        wr_reg(A_SMSK, 32'h7);
        chk_irq("R11 full mask blocks");
        wr_reg(A_SMSK, 32'h6);
        chk_irq("R11 unit0 enabled");
        wr_reg(A_SMSK, 32'h5);
        chk_irq("R11 unit1 enabled");
        wr_reg(ua(0, 2), 32'h0000_0008);
        rd_reg(A_SUM, "R9 three units flagged");
        rd_reg(A_SUM, "R10 unit mask stops reflag");
        rd_reg(A_SMSK, "R11 summary mask readback");

        // R8: event beats a clear in the same cycle
        wr_reg(ua(2, 1), 32'h0000_0020);
        op(1'b1, 1'b0, ua(2, 0), 32'h0000_0020, (NU*CW)'(1) << (2*CW + 5), "", 1'b0);
        rd_reg(ua(2, 0), "R8 event wins over w1c");
        wr_reg(ua(2, 4), 32'h0000_0040);
        wr_reg(ua(2, 1), 32'h0000_0040);
        op(1'b0, 1'b1, ua(2, 0), 32'h0, (NU*CW)'(1) << (2*CW + 6), "R4 read with event", 1'b1);
        rd_reg(ua(2, 0), "R8 event wins over read clear");
        rd_reg(ua(2, 0), "R4 cleared after plain read");
        chk_irq("R11 final level");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule